// File: doc/BRIEF.md
# Speed Mode and Sampling Tap Control Register

This block is a 32-bit control word for a card host interface. It holds a 3-bit code that names the bus speed mode and a 6-bit requested sampling tap. The mode code is presented to the delay stage as soon as it is written. The requested tap is only handed to the delay stage through a self-clearing update flag. Software writes the tap together with the flag, then polls the flag until hardware drops it. When the flag drops, the new tap is in force.

The delay stage can resolve fewer taps than the 6-bit field can encode. Any request at or above the tap limit (43 by default) is applied as tap 0. The flag drops a fixed, parameterised number of cycles after it is raised (2 by default). This keeps the wait well inside the roughly one microsecond that software allows for it. Every pin is a plain control or status signal. The word is written whole, so no handshake or back-pressure applies.

Top module: `spd_tune_ctrl_reg`

## Requirements
- R1: After reset, the mode code, the stored tune value, the update flag, the applied tap and the load strobe are all zero.
- R2: A write captures bits [2:0] into the mode code on the next clock edge, and the code reads back at bits [2:0]. The codes are 0 for SD, 2 for eMMC SDR, 3 for eMMC DDR, 4 for HS200 and 5 for HS400.
- R3: When no update is pending, a write stores bits [13:8] as the requested tune value, and the value reads back at bits [13:8].
- R4: A write with bit 15 at 0 leaves the applied tap unchanged, even when it changes the stored tune value.
- R5: A write with bit 15 at 1, made while no update is pending, sets the update flag, which reads back at bit 15. The flag clears exactly UPD_LAT clock edges later. On that same edge the applied tap takes the stored value, and the load strobe is high for that one cycle only.
- R6: A stored value below TAP_LIMIT is applied unchanged, so 42 is applied as 42. A stored value of TAP_LIMIT or more (43 to 63) is applied as tap 0.
- R7: While an update is pending, the tune and update bits of any write are ignored, and the stored tune value does not change. The mode bits of the same write are still taken.
- R8: Bits [31:16], bit 14 and bits [7:3] always read as zero.
- R9: The applied tap changes in no cycle other than one in which the load strobe is high. A change of mode does not move the tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 32 | Word to write |
| rd_data | output | 32 | Current contents of the word |
| mode_code | output | 3 | Speed mode code for the delay stage |
| tap_index | output | 6 | Sampling tap currently applied |
| tap_load | output | 1 | One-cycle pulse when a new tap is applied |

## Verification
The bench builds the block with UPD_LAT set to 3 rather than the default 2. This makes the countdown pass through an intermediate value and widens the pending window to three cycles. Back-to-back writes can then land in the middle of an update, which is the case R7 covers. TAP_LIMIT stays at 43, so taps 42, 43 and 63 all sit inside the 6-bit field. This places both sides of the wrap boundary within reach. A behavioural model is compared with every output on every cycle, alongside the directed checks.

// File: rtl/spd_tune_pkg.sv
package spd_tune_pkg;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 3;
  localparam int TUNE_LSB = 8;
  localparam int TUNE_W   = 6;
  localparam int UPD_BIT  = 15;

  typedef enum logic [MODE_W-1:0] {
    SPD_SD      = 3'd0,
    SPD_MMC_SDR = 3'd2,
    SPD_MMC_DDR = 3'd3,
    SPD_HS200   = 3'd4,
    SPD_HS400   = 3'd5
  } spd_mode_e;
endpackage

// File: rtl/spd_mode_field.sv
module spd_mode_field #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mode_q <= '0;
    else if (load) mode_q <= din;
  end

  // R2: a write is visible on the following cycle
  assert_mode_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode_q == $past(din)));
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q));
endmodule

// File: rtl/spd_tap_wrap.sv
module spd_tap_wrap #(
  parameter int W     = 6,
  parameter int LIMIT = 43
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] tap
);
  localparam int FULL = 1 << W;

  generate
    if (LIMIT >= FULL) begin : g_pass
      assign tap = req;
    end else begin : g_wrap
      localparam logic [W-1:0] LIM = W'(LIMIT);
      assign tap = (req >= LIM) ? '0 : req;
    end
  endgenerate
endmodule

// File: rtl/spd_tune_update.sv
module spd_tune_update #(
  parameter int TUNE_W    = 6,
  parameter int UPD_LAT   = 2,
  parameter int TAP_LIMIT = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TUNE_W-1:0] wr_tune,
  input  logic              wr_req,
  output logic [TUNE_W-1:0] tune_q,
  output logic              pend_q,
  output logic [TUNE_W-1:0] tap_q,
  output logic              tap_load
);
  localparam int CNT_W = (UPD_LAT < 2) ? 1 : $clog2(UPD_LAT);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(UPD_LAT - 1);
  localparam int AGE_W = $clog2(UPD_LAT + 2);

  logic [CNT_W-1:0]  cnt_q;
  logic [TUNE_W-1:0] tap_next;
  logic              accept;
  logic              done;

  assign accept = wr_en && !pend_q;
  assign done   = pend_q && (cnt_q == '0);

  spd_tap_wrap #(.W(TUNE_W), .LIMIT(TAP_LIMIT)) u_wrap (
    .req (tune_q),
    .tap (tap_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tune_q   <= '0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      tap_q    <= '0;
      tap_load <= 1'b0;
    end else begin
      tap_load <= done;
      if (done) begin
        tap_q  <= tap_next;
        pend_q <= 1'b0;
      end else if (pend_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (accept) begin
        tune_q <= wr_tune;
        if (wr_req) begin
          pend_q <= 1'b1;
          cnt_q  <= CNT_INIT;
        end
      end
    end
  end

  // Independent age counter for the pending window
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      age_q <= '0;
    else if (pend_q) age_q <= age_q + 1'b1;
    else             age_q <= '0;
  end

  assert_flag_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (age_q < AGE_W'(UPD_LAT)));
  assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && age_q == AGE_W'(UPD_LAT - 1)) |=> (!pend_q && tap_load));
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pend_q) |=> $stable(tune_q));
  assert_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load |=> !tap_load);
endmodule

// File: rtl/spd_tune_ctrl_reg.sv
module spd_tune_ctrl_reg #(
  parameter int DATA_W    = 32,
  parameter int UPD_LAT   = 2,
  parameter int TAP_LIMIT = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        mode_code,
  output logic [5:0]        tap_index,
  output logic              tap_load
);
  import spd_tune_pkg::*;

  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'((1 << MODE_W) - 1) << MODE_LSB) |
    (DATA_W'((1 << TUNE_W) - 1) << TUNE_LSB) |
    (DATA_W'(1) << UPD_BIT);

  logic [MODE_W-1:0] mode_q;
  logic [TUNE_W-1:0] tune_q;
  logic [TUNE_W-1:0] tap_q;
  logic              pend_q;
  logic              load_q;

  spd_mode_field #(.W(MODE_W)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wr_en),
    .din    (wr_data[MODE_LSB +: MODE_W]),
    .mode_q (mode_q)
  );

  spd_tune_update #(
    .TUNE_W    (TUNE_W),
    .UPD_LAT   (UPD_LAT),
    .TAP_LIMIT (TAP_LIMIT)
  ) u_tune (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_tune  (wr_data[TUNE_LSB +: TUNE_W]),
    .wr_req   (wr_data[UPD_BIT]),
    .tune_q   (tune_q),
    .pend_q   (pend_q),
    .tap_q    (tap_q),
    .tap_load (load_q)
  );

  always_comb begin
    rd_data                       = '0;
    rd_data[MODE_LSB +: MODE_W]   = mode_q;
    rd_data[TUNE_LSB +: TUNE_W]   = tune_q;
    rd_data[UPD_BIT]              = pend_q;
  end

  assign mode_code = mode_q;
  assign tap_index = tap_q;
  assign tap_load  = load_q;

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == '0);
  assert_tap_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tap_index < 6'(TAP_LIMIT));
  assert_tap_only_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_index) |-> tap_load);
  assert_load_drops_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load |-> !rd_data[UPD_BIT]);
endmodule

// File: tb/spd_tune_ctrl_reg_bench.sv
module spd_tune_ctrl_reg_bench;
  localparam int LAT = 3;
  localparam int LIM = 43;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0]  mode_code;
  logic [5:0]  tap_index;
  logic        tap_load;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  spd_tune_ctrl_reg #(.DATA_W(32), .UPD_LAT(LAT), .TAP_LIMIT(LIM)) u_spd_tune_ctrl_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .mode_code (mode_code),
    .tap_index (tap_index),
    .tap_load  (tap_load)
  );

  // Behavioural reference model
  int m_mode, m_tune, m_tap, m_pend, m_cnt, m_load;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_tune = 0; m_tap = 0; m_pend = 0; m_cnt = 0; m_load = 0;
    end else begin
      automatic int was_pend = m_pend;
      m_load = 0;
      if (m_pend != 0) begin
        if (m_cnt == 0) begin
          m_tap  = (m_tune >= LIM) ? 0 : m_tune;
          m_pend = 0;
          m_load = 1;
        end else m_cnt = m_cnt - 1;
      end
      if (wr_en) begin
        m_mode = int'(wr_data[2:0]);
        if (was_pend == 0) begin
          m_tune = int'(wr_data[13:8]);
          if (wr_data[15]) begin
            m_pend = 1;
            m_cnt  = LAT - 1;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 mode_code", int'(mode_code), m_mode);
      chk("R9 tap_index", int'(tap_index), m_tap);
      chk("R5 tap_load", int'(tap_load), m_load);
      chk("R8 rd_data", int'(rd_data), (m_pend << 15) | (m_tune << 8) | m_mode);
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] word(input int mode, input int tune, input bit upd);
    return (32'(upd) << 15) | (32'(tune) << 8) | 32'(mode);
  endfunction

  // Request tap, wait out the update and check it
  task automatic do_update(input int mode, input int tune, input int exp_tap, input string tag);
    wr(word(mode, tune, 1'b1));
    chk({tag, " flag set"}, int'(rd_data[15]), 1);
    for (int i = 0; i < LAT - 1; i++) begin
      @(negedge clk);
      chk({tag, " flag held"}, int'(rd_data[15]), 1);
    end
    @(negedge clk);
    chk({tag, " flag clear"}, int'(rd_data[15]), 0);
    chk({tag, " tap"}, int'(tap_index), exp_tap);
    chk({tag, " strobe"}, int'(tap_load), 1);
    @(negedge clk);
    chk({tag, " strobe drop"}, int'(tap_load), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 tap", int'(tap_index), 0);
    chk("R1 load", int'(tap_load), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: each mode code
    wr(word(int'(spd_tune_pkg::SPD_HS200), 0, 1'b0));
    chk("R2 hs200", int'(mode_code), 4);
    wr(word(int'(spd_tune_pkg::SPD_MMC_DDR), 0, 1'b0));
    chk("R2 ddr", int'(mode_code), 3);
    wr(word(int'(spd_tune_pkg::SPD_HS400), 0, 1'b0));
    chk("R2 hs400 readback", int'(rd_data[2:0]), 5);

    // R3, R4: store without update, tap stays
    wr(word(2, 17, 1'b0));
    chk("R3 tune readback", int'(rd_data[13:8]), 17);
    chk("R4 tap unchanged", int'(tap_index), 0);

    // R5: update applies after latency
    do_update(4, 17, 17, "R5");
    // R6: boundaries
    do_update(4, 42, 42, "R6 top tap");
    do_update(4, 43, 0, "R6 wrap 43");
    do_update(4, 30, 30, "R6 reload");
    do_update(4, 63, 0, "R6 wrap 63");
    do_update(4, 1, 1, "R6 tap1");

    // R7: writes during pending are ignored for tune
    wr(word(4, 25, 1'b1));
    wr(word(5, 9, 1'b1));
    chk("R7 tune kept", int'(rd_data[13:8]), 25);
    chk("R7 mode taken", int'(mode_code), 5);
    repeat (LAT) @(negedge clk);
    chk("R7 applied first", int'(tap_index), 25);

    // R9: mode change does not move the tap
    wr(word(0, 25, 1'b0));
    chk("R9 mode no tap move", int'(tap_index), 25);
    // R8: reserved bits written high read back zero
    wr(32'hFFFF_78F8 | word(3, 40, 1'b0));
    chk("R8 reserved", int'(rd_data & 32'hFFFF_40F8), 0);
    chk("R4 tap still", int'(tap_index), 25);
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule